// File: doc/BRIEF.md
# External Bus Transfer Termination Controller

This block runs one chip-selected transfer at a time on an external bus and decides the cycle in which it ends. An internal requester presents a read or write. If the controller is idle and its configuration is marked valid, it takes the request, pulls its active-low chip select low and, for a write, starts driving write data with its output enable high.

The transfer ends in one of two ways. With auto-acknowledge on, the controller counts a programmed number of wait states and acknowledges the transfer itself. The external device may still end the transfer sooner with its active-low acknowledge input. With auto-acknowledge off, only the external acknowledge ends the transfer, and the controller waits for it with no time limit. The external acknowledge is honoured only while chip select is low.

After the acknowledge, chip select rises on the next cycle and a one-cycle done pulse appears in that same cycle. Read data is captured in the acknowledge cycle. On a write, the data stays driven for one further cycle after chip select rises. A small write-only configuration port holds the valid bit, the auto-acknowledge enable and the wait-state count. A write to a reserved address returns a bus error and changes nothing.

Top module: `ebt_ctrl`

## Requirements
- R1: After reset, chip select is high (inactive), write output enable is low, done is low, and every configuration field is zero: valid clear, auto-acknowledge off, wait count 0.
- R2: While the valid bit is clear, req_ready is low and a request is ignored: chip select stays high and done stays low.
- R3: With auto-acknowledge on and no external acknowledge, chip select is low for exactly W+1 cycles, where W is the 6-bit wait count. W=0 ends the transfer in the first data cycle.
- R4: With auto-acknowledge on, an external acknowledge (bus_ta_n low) in data cycle i < W ends the transfer at cycle i.
- R5: With auto-acknowledge off, the transfer ends only in the data cycle in which bus_ta_n is low. Without it, chip select stays low and done never rises, however long the wait.
- R6: Chip select goes high one cycle after the acknowledge cycle, and done is high for exactly that one cycle.
- R7: On a write, bus_wdata holds the request data while chip select is low and for one cycle after it rises, with bus_wdata_oe high over the same span. bus_wdata_oe is low on the cycle after that.
- R8: On a read, rd_data shows the bus_rdata value sampled in the acknowledge cycle, starting with the done cycle.
- R9: bus_ta_n low while chip select is high has no effect. It does not raise done, does not start a transfer, and leaves no pending acknowledge for the next transfer.
- R10: Configuration map: address 0 takes bit 0 as valid and bit 1 as auto-acknowledge, and address 1 takes bits 5:0 as the wait count. Addresses 2 and 3 are reserved. A write to a reserved address raises cfg_err in the following cycle and leaves all fields unchanged. A write to address 0 or 1 leaves cfg_err low.
- R11: A request is accepted only when the controller is idle, as shown by req_ready high. A request made while a transfer or its write hold cycle is in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address |
| cfg_wdata | input | 6 | Configuration write data |
| cfg_err | output | 1 | Bus error for a reserved-address write, one cycle after the write |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data of the request |
| req_ready | output | 1 | Idle and configured; a request is taken |
| done | output | 1 | One-cycle transfer completion pulse |
| rd_data | output | 32 | Captured read data |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_wdata | output | 32 | Write data to the bus |
| bus_wdata_oe | output | 1 | Write data output enable |
| bus_rdata | input | 32 | Read data from the bus |
| bus_ta_n | input | 1 | Active-low external transfer acknowledge |

## Verification
The bench targets the edges of the wait count. With W=0, a design that counts one cycle too many holds chip select for two cycles instead of one. An external acknowledge exactly at, before or after the countdown end would expose a controller that ignores the early path or acts on an acknowledge that comes too late. With auto-acknowledge off and no acknowledge, the bench holds the transfer for a long stretch: a design that times out or falls back to the wait count releases chip select. Acknowledges given while idle, requests made while busy and reserved-address writes each test for a stray transfer, a latched acknowledge or a corrupted wait count, and any of these would show up as wrong chip-select timing on the next transfer.

// File: rtl/ebt_pkg.sv
package ebt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_HOLD = 2'd2
    } ebt_state_e;

    localparam logic [1:0] CFG_ADDR_CTRL = 2'd0;
    localparam logic [1:0] CFG_ADDR_WAIT = 2'd1;
endpackage

// File: rtl/ebt_cfg_regs.sv
module ebt_cfg_regs #(
    parameter int WS_W   = 6,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WS_W-1:0]   wdata,
    output logic              valid_o,
    output logic              aa_o,
    output logic [WS_W-1:0]   ws_o,
    output logic              err_o
);
    import ebt_pkg::*;

    typedef struct packed {
        logic            valid;
        logic            aa;
        logic [WS_W-1:0] ws;
        logic            err;
    } cfg_t;

    cfg_t c_d, c_q;
    logic reserved;

    assign reserved = (addr != ADDR_W'(CFG_ADDR_CTRL)) && (addr != ADDR_W'(CFG_ADDR_WAIT));

    always_comb begin
        c_d     = c_q;
        c_d.err = 1'b0;
        if (we) begin
            if (reserved) begin
                c_d.err = 1'b1;
            end else if (addr == ADDR_W'(CFG_ADDR_CTRL)) begin
                c_d.valid = wdata[0];
                c_d.aa    = wdata[1];
            end else begin
                c_d.ws = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign valid_o = c_q.valid;
    assign aa_o    = c_q.aa;
    assign ws_o    = c_q.ws;
    assign err_o   = c_q.err;

    p_err_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && reserved) |=> err_o);
    p_reserved_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && reserved) |=> ($stable(valid_o) && $stable(aa_o) && $stable(ws_o)));
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> !err_o);
endmodule

// File: rtl/ebt_ws_timer.sv
module ebt_ws_timer #(
    parameter int WS_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WS_W-1:0] ws_in,
    input  logic            run,
    output logic            expire
);
    logic [WS_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                        cnt_d = ws_in;
        else if (run && cnt_q != '0)     cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && (cnt_q == '0);

    p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(ws_in)));
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ebt_ctrl.sv
module ebt_ctrl #(
    parameter int DATA_W = 32,
    parameter int WS_W   = 6,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WS_W-1:0]   cfg_wdata,
    output logic              cfg_err,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_cs_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ta_n
);
    import ebt_pkg::*;

    typedef struct packed {
        ebt_state_e        state;
        logic              cs_n;
        logic              oe;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              aa;
        logic              wr;
    } ctl_t;

    ctl_t r_d, r_q;

    logic            cfg_valid, cfg_aa;
    logic [WS_W-1:0] cfg_ws;
    logic            accept, ext_ack, ack, expire, run;

    ebt_cfg_regs #(.WS_W(WS_W), .ADDR_W(ADDR_W)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .valid_o (cfg_valid),
        .aa_o    (cfg_aa),
        .ws_o    (cfg_ws),
        .err_o   (cfg_err)
    );

    assign run = (r_q.state == ST_DATA);

    ebt_ws_timer #(.WS_W(WS_W)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .ws_in  (cfg_ws),
        .run    (run),
        .expire (expire)
    );

    assign req_ready = (r_q.state == ST_IDLE) && cfg_valid;
    assign accept    = req_ready && req_valid;
    assign ext_ack   = !bus_ta_n && !r_q.cs_n;
    assign ack       = ext_ack || (r_q.aa && expire);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    r_d.state = ST_DATA;
                    r_d.cs_n  = 1'b0;
                    r_d.oe    = req_write;
                    r_d.wdata = req_wdata;
                    r_d.aa    = cfg_aa;
                    r_d.wr    = req_write;
                end
            end
            ST_DATA: begin
                if (ack) begin
                    r_d.cs_n = 1'b1;
                    r_d.done = 1'b1;
                    if (r_q.wr) begin
                        r_d.state = ST_HOLD;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.rdata = bus_rdata;
                    end
                end
            end
            ST_HOLD: begin
                r_d.state = ST_IDLE;
                r_d.oe    = 1'b0;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cs_n: 1'b1, oe: 1'b0, wdata: '0,
                     rdata: '0, done: 1'b0, aa: 1'b0, wr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done         = r_q.done;
    assign rd_data      = r_q.rdata;
    assign bus_cs_n     = r_q.cs_n;
    assign bus_wdata    = r_q.wdata;
    assign bus_wdata_oe = r_q.oe;

    p_no_cs_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_n && !cfg_valid) |=> bus_cs_n);
    p_hang_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !r_q.aa && bus_ta_n) |=> (!bus_cs_n && !done));
    p_cs_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> done);
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_wdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bus_wdata_oe) |=> (!bus_wdata_oe && bus_cs_n && $stable(bus_wdata)));
    p_idle_ta_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_n && !bus_wdata_oe && !req_valid) |=> (bus_cs_n && !done));
    p_busy_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !done) |-> !req_ready);
endmodule

// File: tb/ebt_ctrl_tb_top.sv
`timescale 1ns/1ps
module ebt_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [5:0]  cfg_wdata;
    logic        cfg_err;
    logic        req_valid, req_write, req_ready, done;
    logic [31:0] req_wdata, rd_data, bus_wdata, bus_rdata;
    logic        bus_cs_n, bus_wdata_oe, bus_ta_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ebt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .req_valid(req_valid),
        .req_write(req_write), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .bus_cs_n(bus_cs_n),
        .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
        .bus_rdata(bus_rdata), .bus_ta_n(bus_ta_n)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int end_cycle(bit aa, int ws, int ta_at);
        if (!aa) return ta_at;
        if (ta_at >= 0 && ta_at < ws) return ta_at;
        return ws;
    endfunction

    task automatic cfg_write(logic [1:0] a, logic [5:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        check(a >= 2 ? "R10 err on reserved" : "R10 no err", {31'd0, cfg_err}, {31'd0, a >= 2});
    endtask

    task automatic xfer(bit wr, logic [31:0] data, bit aa, int ws, int ta_at, bit inj);
        int k;
        string tag;
        logic [31:0] exp_rd;
        k = end_cycle(aa, ws, ta_at);
        tag = !aa ? "R5 ext-only end" : ((ta_at >= 0 && ta_at < ws) ? "R4 early ack" : "R3 countdown");
        exp_rd = '0;
        check("R11 ready when idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_wdata = data;
        @(negedge clk);
        for (int i = 0; i <= k + 2; i++) begin
            if (i <= k) check(tag, {31'd0, bus_cs_n}, 32'd0);
            if (i == k + 1) begin
                check("R6 cs released", {31'd0, bus_cs_n}, 32'd1);
                check("R6 done pulse", {31'd0, done}, 32'd1);
                check("R7 oe hold", {31'd0, bus_wdata_oe}, {31'd0, wr});
                if (!wr) check("R8 read capture", rd_data, exp_rd);
            end
            if (i == k + 2) begin
                check("R6 done one cycle", {31'd0, done}, 32'd0);
                check("R7 oe off", {31'd0, bus_wdata_oe}, 32'd0);
                check("R11 no busy accept", {31'd0, bus_cs_n}, 32'd1);
            end
            if (wr && i <= k + 1) check("R7 wdata", bus_wdata, data);
            bus_ta_n  = !(i == ta_at);
            bus_rdata = $urandom;
            if (i == k) exp_rd = bus_rdata;
            req_valid = (i == 0) ? inj : 1'b0;
            req_write = $urandom % 2;
            @(negedge clk);
        end
        bus_ta_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        check("R11 dropped request", {31'd0, bus_cs_n}, 32'd1);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        req_valid = 0; req_write = 0; req_wdata = 0; bus_rdata = 0; bus_ta_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cs idle", {31'd0, bus_cs_n}, 32'd1);
        check("R1 oe low", {31'd0, bus_wdata_oe}, 32'd0);
        check("R1 done low", {31'd0, done}, 32'd0);
        check("R1 valid clear", {31'd0, req_ready}, 32'd0);

        // R2: request while invalid is ignored
        req_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check("R2 no cs invalid", {31'd0, bus_cs_n}, 32'd1);
            check("R2 no done invalid", {31'd0, done}, 32'd0);
        end
        req_valid = 1'b0;

        // R1: wait count resets to zero, so auto-ack ends in first cycle
        cfg_write(2'd0, 6'b000011);
        xfer(1'b0, 32'h0, 1'b1, 0, -1, 1'b0);
        xfer(1'b1, 32'hA5A5_0001, 1'b1, 0, -1, 1'b1);

        // R3 at the top of the field
        cfg_write(2'd1, 6'd63);
        xfer(1'b0, 32'h0, 1'b1, 63, -1, 1'b0);

        // R9: acknowledge while idle ignored
        cfg_write(2'd1, 6'd3);
        bus_ta_n = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check("R9 idle ta no done", {31'd0, done}, 32'd0);
            check("R9 idle ta no cs", {31'd0, bus_cs_n}, 32'd1);
        end
        bus_ta_n = 1'b1;
        xfer(1'b0, 32'h0, 1'b1, 3, -1, 1'b0);

        // R10: reserved writes do not touch wait count
        cfg_write(2'd2, 6'd0);
        cfg_write(2'd3, 6'd0);
        xfer(1'b1, 32'h1234_5678, 1'b1, 3, -1, 1'b0);

        // R4 boundaries: ack at ws-1, at ws, after ws
        xfer(1'b0, 32'h0, 1'b1, 3, 2, 1'b0);
        xfer(1'b0, 32'h0, 1'b1, 3, 3, 1'b0);
        xfer(1'b1, 32'hDEAD_BEEF, 1'b1, 3, 5, 1'b1);

        // R5: hang without external acknowledge
        cfg_write(2'd0, 6'b000001);
        cfg_write(2'd1, 6'd0);
        req_valid = 1'b1; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (200) begin
            check("R5 hang cs", {31'd0, bus_cs_n}, 32'd0);
            check("R5 hang no done", {31'd0, done}, 32'd0);
            @(negedge clk);
        end
        bus_ta_n = 1'b0; bus_rdata = 32'hCAFE_0005;
        @(negedge clk);
        bus_ta_n = 1'b1;
        check("R5 release", {31'd0, bus_cs_n}, 32'd1);
        check("R8 hang read", rd_data, 32'hCAFE_0005);
        @(negedge clk);

        // Random mix
        for (int n = 0; n < 60; n++) begin
            bit aa, wr, inj;
            int ws, ta;
            aa  = $urandom % 2;
            wr  = $urandom % 2;
            inj = $urandom % 2;
            ws  = $urandom % 12;
            if (aa && ($urandom % 3 == 0)) ta = -1;
            else ta = $urandom % 14;
            cfg_write(2'd0, {4'd0, aa, 1'b1});
            cfg_write(2'd1, 6'(ws));
            xfer(wr, $urandom, aa, ws, ta, inj);
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule